// File: doc/BRIEF.md
# Dual-Source Transmit Frame Sequencer

This block turns host payload bytes into a stream of 4-bit symbols for a low-rate wireless PHY transmitter. Each frame is a header (four zero preamble bytes, a start delimiter 0xA7 and a length byte), then the payload, then a 16-bit frame check sequence. Every byte leaves as two symbols, low nibble first. A downstream spreader pulls the symbols through a valid/ready pair.

The payload comes from one of two sources, picked by `tx_mode` when the transmit request is taken. In packet mode (`tx_mode`=0) the host first writes the whole payload into a local buffer through a valid/ready byte port, then raises `tx_req`. It gets one `irq_done` pulse when the last symbol has left. In stream mode (`tx_mode`=1) the host gives the payload length with the request. It then feeds bytes one at a time through a second valid/ready port. `st_ready` is the level request line: while it is high, the block wants the next byte. If a payload byte is needed and none is held, the frame is aborted and `irq_err` pulses.

Back-pressure rules: a byte moves on `wr_*`, `st_*` or `sym_*` only in a cycle where both valid and ready are high at the rising edge. While `sym_valid` is high and `sym_ready` is low, the symbol is held unchanged. The host may hold `wr_valid` or `st_valid` high for as long as it likes. A byte offered while ready is low is not taken.

Top module: `txfrm_ctrl`

## Requirements
- R1: After reset, `busy`, `sym_valid`, `st_ready`, `irq_done` and `irq_err` are 0 and `wr_ready` is 1.
- R2: A frame carries, in this order: four 0x00 bytes, 0xA7, a length byte equal to payload count plus 2 (bit 7 zero), the payload bytes, then the check value low byte first.
- R3: Each byte is sent as two symbols on `sym_data`, bits 3:0 first and then bits 7:4. One symbol moves per cycle with `sym_valid` and `sym_ready` both high. A held symbol stays valid and unchanged until taken.
- R4: The check value is a CRC-16 over the payload only. It uses polynomial x^16+x^12+x^5+1, initial value 0, and bits taken LSB first (reflected form, constant 0x8408). For the ASCII bytes "123456789" it is 0x2189.
- R5: In packet mode the payload is every byte written over `wr_*` since the last packet-mode frame ended, in write order. The buffer empties when that frame completes. `wr_ready` is low while `busy` or while 125 bytes are held.
- R6: `tx_req` in an idle cycle starts a frame and samples `tx_mode`. `busy` is high from the next cycle until the cycle after the last symbol moves. A `tx_req` while `busy` is ignored.
- R7: `irq_done` is a one-cycle pulse in the cycle after the last check symbol moves.
- R8: In stream mode, `st_ready` is high only while a stream frame is busy, the one-byte holding register is empty, and fewer than `tx_len` bytes have been accepted.
- R9: In stream mode, when a payload byte's first symbol is due and no byte is held, `sym_valid` is low. If `sym_ready` is high in that cycle, the frame is aborted: `irq_err` pulses in the next cycle and `busy` drops at the same time, with no `irq_done`.
- R10: A stream-mode request with `tx_len` above 125 is ignored; `busy` stays low.
- R11: A zero-byte payload (empty buffer, or `tx_len`=0) gives a 16-symbol frame with length byte 0x02 and check value 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_req | input | 1 | Transmit request |
| tx_mode | input | 1 | 0 packet buffer, 1 streaming; sampled with `tx_req` |
| tx_len | input | LEN_W | Stream-mode payload byte count |
| wr_valid | input | 1 | Buffer write byte valid |
| wr_ready | output | 1 | Buffer can take a byte |
| wr_data | input | 8 | Buffer write byte |
| st_valid | input | 1 | Stream byte valid |
| st_ready | output | 1 | Stream byte wanted (host request line) |
| st_data | input | 8 | Stream byte |
| sym_valid | output | 1 | Symbol valid |
| sym_ready | input | 1 | Downstream takes the symbol |
| sym_data | output | 4 | Symbol |
| busy | output | 1 | Frame in progress |
| irq_done | output | 1 | Frame-complete pulse |
| irq_err | output | 1 | Stream underrun pulse |

## Verification
Packet mode is run with the "123456789" payload and a steady downstream, which pins the header layout, nibble order and the known check value. A random 20-byte payload under random `sym_ready` stalls, with a stray request mid-frame, separates correct holding and request blocking from sequencing that only works at full rate. Streaming with a prompt host shows that the holding register keeps up. Streaming with a host that stops after three of eight bytes must abort exactly at the fourth payload byte. An empty payload, a stream length of 126 and a completely full buffer exercise the length edges.

// File: rtl/txf_pkg.sv
package txf_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HDR  = 2'd1,
    PH_PAY  = 2'd2,
    PH_FCS  = 2'd3
  } txf_phase_e;

  localparam logic [7:0]  TXF_SFD       = 8'hA7;
  localparam logic [15:0] TXF_CRC_REFL  = 16'h8408;
  localparam int          TXF_FCS_BYTES = 2;
endpackage

// File: rtl/txf_pktbuf.sv
module txf_pktbuf #(
  parameter int AW      = 7,
  parameter int MAX_CNT = 125
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_allow,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [7:0]    wr_data,
  input  logic          clear,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic [AW-1:0] count
);
  localparam int DEPTH = 2**AW;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] cnt_q;

  assign wr_ready = wr_allow && (cnt_q < AW'(MAX_CNT));
  assign count    = cnt_q;
  assign rd_data  = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (wr_valid && wr_ready) begin
      cnt_q <= cnt_q + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_valid && wr_ready) mem[cnt_q] <= wr_data;
  end
endmodule

// File: rtl/txf_strm_hold.sv
module txf_strm_hold #(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic             active,
  input  logic             flush,
  input  logic             consume,
  input  logic             st_valid,
  output logic             st_ready,
  input  logic [7:0]       st_data,
  output logic             full,
  output logic [7:0]       data
);
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] acc_q;
  logic             full_q;
  logic [7:0]       data_q;

  assign st_ready = active && !full_q && (acc_q < len_q);
  assign full     = full_q;
  assign data     = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      acc_q  <= '0;
      full_q <= 1'b0;
      data_q <= '0;
    end else if (start) begin
      len_q  <= len;
      acc_q  <= '0;
      full_q <= 1'b0;
    end else if (flush) begin
      full_q <= 1'b0;
    end else begin
      if (consume) full_q <= 1'b0;
      if (st_valid && st_ready) begin
        full_q <= 1'b1;
        data_q <= st_data;
        acc_q  <= acc_q + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/txf_crc16.sv
module txf_crc16 #(
  parameter logic [15:0] POLY = 16'h8408
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  logic [15:0] crc_q;
  logic [15:0] nxt;

  always_comb begin
    nxt = crc_q;
    for (int b = 0; b < 8; b++) begin
      if (nxt[0] ^ din[b]) nxt = (nxt >> 1) ^ POLY;
      else                 nxt = nxt >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= '0;
    else if (clear)  crc_q <= '0;
    else if (en)     crc_q <= nxt;
  end

  assign crc = crc_q;
endmodule

// File: rtl/txfrm_ctrl.sv
module txfrm_ctrl
  import txf_pkg::*;
#(
  parameter int LEN_W     = 7,
  parameter int PRE_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_req,
  input  logic             tx_mode,
  input  logic [LEN_W-1:0] tx_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  input  logic             st_valid,
  output logic             st_ready,
  input  logic [7:0]       st_data,
  output logic             sym_valid,
  input  logic             sym_ready,
  output logic [3:0]       sym_data,
  output logic             busy,
  output logic             irq_done,
  output logic             irq_err
);
  localparam int DEPTH     = 2**LEN_W;
  localparam int MAX_PAY   = DEPTH - 1 - TXF_FCS_BYTES;
  localparam int HDR_BYTES = PRE_BYTES + 2;
  localparam logic [LEN_W-1:0] MAX_PAY_L  = LEN_W'(MAX_PAY);
  localparam logic [LEN_W-1:0] HDR_LAST_L = LEN_W'(HDR_BYTES - 1);
  localparam logic [LEN_W-1:0] SFD_IDX_L  = LEN_W'(PRE_BYTES);
  localparam logic [LEN_W-1:0] FCS_LAST_L = LEN_W'(TXF_FCS_BYTES - 1);

  txf_phase_e       phase_q;
  logic [LEN_W-1:0] idx_q;
  logic             nib_q;
  logic [LEN_W-1:0] len_q;
  logic             strm_q;
  logic [7:0]       pay_lat_q;
  logic             done_q;
  logic             err_q;

  logic             start, fire, pay_lo, starve, underrun, frame_end;
  logic [7:0]       buf_rd, hold_data, lo_byte, cur_byte, hdr_byte;
  logic [LEN_W-1:0] buf_cnt;
  logic             hold_full;
  logic [15:0]      crc;

  assign busy      = (phase_q != PH_IDLE);
  assign pay_lo    = (phase_q == PH_PAY) && !nib_q;
  assign starve    = strm_q && pay_lo && !hold_full;
  assign sym_valid = busy && !starve;
  assign fire      = sym_valid && sym_ready;
  assign underrun  = busy && starve && sym_ready;
  assign start     = !busy && tx_req && (!tx_mode || (tx_len <= MAX_PAY_L));
  assign frame_end = fire && nib_q && (phase_q == PH_FCS) && (idx_q == FCS_LAST_L);
  assign irq_done  = done_q;
  assign irq_err   = err_q;

  txf_pktbuf #(.AW(LEN_W), .MAX_CNT(MAX_PAY)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_allow (!busy),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_data  (wr_data),
    .clear    (frame_end && !strm_q),
    .rd_addr  (idx_q),
    .rd_data  (buf_rd),
    .count    (buf_cnt)
  );

  txf_strm_hold #(.LEN_W(LEN_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .len      (tx_len),
    .active   (busy && strm_q),
    .flush    (underrun),
    .consume  (fire && pay_lo && strm_q),
    .st_valid (st_valid),
    .st_ready (st_ready),
    .st_data  (st_data),
    .full     (hold_full),
    .data     (hold_data)
  );

  txf_crc16 #(.POLY(TXF_CRC_REFL)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start),
    .en    (fire && pay_lo),
    .din   (lo_byte),
    .crc   (crc)
  );

  // Header generator: preamble zeros, delimiter, then length with FCS bytes added
  always_comb begin
    if (idx_q < SFD_IDX_L)       hdr_byte = 8'h00;
    else if (idx_q == SFD_IDX_L) hdr_byte = TXF_SFD;
    else                         hdr_byte = 8'(len_q + LEN_W'(TXF_FCS_BYTES));
  end

  assign lo_byte = strm_q ? hold_data : buf_rd;

  // Frame multiplexer: header, payload, check value in turn
  always_comb begin
    unique case (phase_q)
      PH_HDR:  cur_byte = hdr_byte;
      PH_PAY:  cur_byte = nib_q ? pay_lat_q : lo_byte;
      PH_FCS:  cur_byte = (idx_q == '0) ? crc[7:0] : crc[15:8];
      default: cur_byte = 8'h00;
    endcase
  end

  assign sym_data = nib_q ? cur_byte[7:4] : cur_byte[3:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      idx_q     <= '0;
      nib_q     <= 1'b0;
      len_q     <= '0;
      strm_q    <= 1'b0;
      pay_lat_q <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (start) begin
        phase_q <= PH_HDR;
        idx_q   <= '0;
        nib_q   <= 1'b0;
        strm_q  <= tx_mode;
        len_q   <= tx_mode ? tx_len : buf_cnt;
      end else if (underrun) begin
        phase_q <= PH_IDLE;
        err_q   <= 1'b1;
      end else if (fire) begin
        if (!nib_q) begin
          nib_q <= 1'b1;
          if (phase_q == PH_PAY) pay_lat_q <= lo_byte;
        end else begin
          nib_q <= 1'b0;
          unique case (phase_q)
            PH_HDR: begin
              if (idx_q == HDR_LAST_L) begin
                idx_q   <= '0;
                phase_q <= (len_q == '0) ? PH_FCS : PH_PAY;
              end else begin
                idx_q <= idx_q + LEN_W'(1);
              end
            end
            PH_PAY: begin
              if (idx_q == len_q - LEN_W'(1)) begin
                idx_q   <= '0;
                phase_q <= PH_FCS;
              end else begin
                idx_q <= idx_q + LEN_W'(1);
              end
            end
            PH_FCS: begin
              if (idx_q == FCS_LAST_L) begin
                phase_q <= PH_IDLE;
                idx_q   <= '0;
                done_q  <= 1'b1;
              end else begin
                idx_q <= idx_q + LEN_W'(1);
              end
            end
            default: phase_q <= PH_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/txfrm_ctrl_chk.sv
module txfrm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_req,
  input logic       wr_ready,
  input logic       st_ready,
  input logic       sym_valid,
  input logic       sym_ready,
  input logic [3:0] sym_data,
  input logic       busy,
  input logic       irq_done,
  input logic       irq_err
);
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !sym_ready) |=> (sym_valid && $stable(sym_data)));

  a_r5_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ready);

  a_r6_start_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tx_req));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> (!busy && !irq_err) ##1 !irq_done);

  a_r7_done_after_symbol: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> ($past(sym_valid) && $past(sym_ready)));

  a_r8_ready_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    st_ready |-> busy);

  a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> (!busy && !sym_valid && $past(busy) && !$past(sym_valid)));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sym_valid && !st_ready));
endmodule

bind txfrm_ctrl txfrm_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_req    (tx_req),
  .wr_ready  (wr_ready),
  .st_ready  (st_ready),
  .sym_valid (sym_valid),
  .sym_ready (sym_ready),
  .sym_data  (sym_data),
  .busy      (busy),
  .irq_done  (irq_done),
  .irq_err   (irq_err)
);

// File: tb/txfrm_ctrl_tb.sv
`timescale 1ns/100ps
module txfrm_ctrl_tb;
  localparam int LEN_W = 7;
  localparam int MAXP  = 125;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tx_req = 1'b0, tx_mode = 1'b0;
  logic [LEN_W-1:0] tx_len = '0;
  logic             wr_valid = 1'b0;
  logic [7:0]       wr_data = '0;
  logic             st_valid = 1'b0;
  logic [7:0]       st_data = '0;
  logic             sym_ready = 1'b1;
  logic             wr_ready, st_ready, sym_valid, busy, irq_done, irq_err;
  logic [3:0]       sym_data;

  always #2.5 clk = ~clk;

  txfrm_ctrl #(.LEN_W(LEN_W), .PRE_BYTES(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_mode(tx_mode), .tx_len(tx_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data),
    .sym_valid(sym_valid), .sym_ready(sym_ready), .sym_data(sym_data),
    .busy(busy), .irq_done(irq_done), .irq_err(irq_err)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Reference model state. Queue entry: [3:0] symbol, [4] payload low nibble, [6:5] part
  bit         model_on = 1'b0;
  bit         m_busy = 1'b0, m_strm = 1'b0, m_done = 1'b0, m_err = 1'b0;
  int         m_hold = 0, m_acc = 0, m_len = 0, m_fires = 0, m_errs = 0;
  logic [6:0] m_q[$];
  logic [7:0] m_buf[$];
  logic [7:0] pay_tmp[$];
  logic [7:0] feed_q[$];
  int         feed_i = 0, feed_n = 0;
  bit         feed_en = 1'b0, stall_en = 1'b0, st_fire_seen = 1'b0;

  function automatic logic [15:0] ref_crc();
    logic [15:0] c = 16'h0000;
    foreach (pay_tmp[k]) begin
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ pay_tmp[k][b];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    end
    return c;
  endfunction

  function automatic void push_byte(input logic [7:0] v, input logic [1:0] part, input bit is_pay);
    m_q.push_back({part, is_pay, v[3:0]});
    m_q.push_back({part, 1'b0, v[7:4]});
  endfunction

  function automatic void build();
    logic [15:0] c = ref_crc();
    for (int k = 0; k < 4; k++) push_byte(8'h00, 2'd0, 1'b0);
    push_byte(8'hA7, 2'd0, 1'b0);
    push_byte(8'(pay_tmp.size() + 2), 2'd0, 1'b0);
    foreach (pay_tmp[k]) push_byte(pay_tmp[k], 2'd1, 1'b1);
    push_byte(c[7:0], 2'd2, 1'b0);
    push_byte(c[15:8], 2'd2, 1'b0);
  endfunction

  always @(negedge clk) begin
    if (model_on) begin
      bit e_lo, e_starve, e_sv, e_st, e_wr;
      e_lo     = (m_q.size() > 0) && m_q[0][4];
      e_starve = m_busy && m_strm && e_lo && (m_hold == 0);
      e_sv     = m_busy && !e_starve;
      e_st     = m_busy && m_strm && (m_hold == 0) && (m_acc < m_len);
      e_wr     = !m_busy && (m_buf.size() < MAXP);
      chk("R6", "busy", busy, m_busy);
      chk("R5", "wr_ready", wr_ready, e_wr);
      chk("R8", "st_ready", st_ready, e_st);
      chk("R9", "sym_valid", sym_valid, e_sv);
      chk("R7", "irq_done", irq_done, m_done);
      chk("R9", "irq_err", irq_err, m_err);
      st_fire_seen = st_valid && st_ready;
      m_done = 1'b0;
      m_err  = 1'b0;
      if (wr_valid && e_wr) m_buf.push_back(wr_data);
      if (m_busy) begin
        if (e_starve && sym_ready) begin
          m_busy = 1'b0; m_err = 1'b1; m_errs++; m_q.delete();
        end else begin
          if (e_st && st_valid) begin m_hold++; m_acc++; end
          if (e_sv && sym_ready) begin
            case (m_q[0][6:5])
              2'd0:    chk("R2", "header symbol", sym_data, m_q[0][3:0]);
              2'd1:    chk("R3", "payload symbol", sym_data, m_q[0][3:0]);
              default: chk("R4", "check symbol", sym_data, m_q[0][3:0]);
            endcase
            if (m_q[0][4] && m_strm) m_hold--;
            void'(m_q.pop_front());
            m_fires++;
            if (m_q.size() == 0) begin
              m_busy = 1'b0; m_done = 1'b1;
              if (!m_strm) m_buf.delete();
            end
          end
        end
      end else if (tx_req) begin
        if (!tx_mode) begin
          m_strm = 1'b0; pay_tmp = m_buf; build(); m_busy = 1'b1;
        end else if (int'(tx_len) <= MAXP) begin
          m_strm = 1'b1; m_len = int'(tx_len); m_hold = 0; m_acc = 0;
          pay_tmp.delete();
          for (int k = 0; k < m_len; k++) pay_tmp.push_back(feed_q[k]);
          build(); m_busy = 1'b1;
        end
      end
    end
  end

  // Stream host and downstream stall driver
  always @(posedge clk) begin
    #1;
    if (st_fire_seen) feed_i++;
    st_valid = feed_en && (feed_i < feed_n);
    st_data  = st_valid ? feed_q[feed_i] : 8'h00;
    sym_ready = stall_en ? (($urandom % 4) != 0) : 1'b1;
  end

  task automatic do_req(input logic mode, input int len);
    @(posedge clk); #1;
    tx_req = 1'b1; tx_mode = mode; tx_len = LEN_W'(len);
    @(posedge clk); #1;
    tx_req = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_byte(input logic [7:0] d);
    @(posedge clk); #1;
    wr_valid = 1'b1; wr_data = d;
    do @(negedge clk); while (!wr_ready);
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic setup_feed(input int n_total, input int n_give);
    feed_en = 1'b0; feed_i = 0; feed_q.delete();
    for (int k = 0; k < n_total; k++) feed_q.push_back(8'($urandom));
    feed_n = n_give;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "sym_valid", sym_valid, 0);
    chk("R1", "st_ready", st_ready, 0);
    chk("R1", "irq_done", irq_done, 0);
    chk("R1", "irq_err", irq_err, 0);
    chk("R1", "wr_ready", wr_ready, 1);
    @(posedge clk); #1; rst_n = 1'b1;
    model_on = 1'b1;

    // Packet mode, known check vector (R2, R4)
    for (int k = 0; k < 9; k++) wr_byte(8'h31 + 8'(k));
    do_req(1'b0, 0);
    wait_idle();

    // Packet mode, random payload under stalls, stray request while busy (R3, R6)
    stall_en = 1'b1;
    for (int k = 0; k < 20; k++) wr_byte(8'($urandom));
    do_req(1'b0, 0);
    repeat (15) @(posedge clk);
    do_req(1'b1, 5);
    wait_idle();

    // Empty payload (R11)
    m_fires = 0;
    do_req(1'b0, 0);
    wait_idle();
    chk("R11", "symbols in empty frame", m_fires, 16);

    // Stream mode, prompt host (R8)
    setup_feed(10, 10);
    feed_en = 1'b1;
    do_req(1'b1, 10);
    wait_idle();
    feed_en = 1'b0;

    // Stream underrun after three of eight bytes (R9)
    m_errs = 0;
    setup_feed(8, 3);
    feed_en = 1'b1;
    do_req(1'b1, 8);
    wait_idle();
    feed_en = 1'b0;
    chk("R9", "underrun pulses", m_errs, 1);

    // Stream length over the limit (R10)
    setup_feed(126, 0);
    do_req(1'b1, 126);
    repeat (3) @(negedge clk);
    chk("R10", "busy after oversize request", busy, 0);

    // Fill the buffer to its limit, then an extra write is refused (R5)
    stall_en = 1'b0;
    for (int k = 0; k < MAXP; k++) wr_byte(8'(k * 3 + 1));
    @(negedge clk);
    chk("R5", "wr_ready when full", wr_ready, 0);
    @(posedge clk); #1; wr_valid = 1'b1; wr_data = 8'hEE;
    repeat (3) @(posedge clk);
    #1; wr_valid = 1'b0;
    do_req(1'b0, 0);
    wait_idle();
    chk("R5", "wr_ready after full frame", wr_ready, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule